// File: doc/BRIEF.md
# Multi-Threshold Result Encoder

This block takes one cluster energy for each of four azimuthal positions and compares every energy against a bank of seven programmable thresholds, named T1 to T7. From one set of comparisons it produces three packed results. The first is a priority code per position that names the highest-numbered threshold passed. The second is a word of saturating 2-bit object counts for thresholds T1 to T6. The third is an 8-bit pass mask per position. The thresholds are loaded through a plain register write port, which has no handshake.

Energies enter on a valid/ready stream, and the three results leave together on a second valid/ready stream. The result stage holds one entry. The input is ready whenever that entry is empty or is being taken in the same cycle. A result therefore moves out while the next input moves in, so the block runs at one set per clock when the sink does not stall. When `out_ready` is held low, the result stage holds its contents. After that, `in_ready` falls and the upstream source must keep its data until it is accepted.

Top module: `thr_result_encoder`

## Requirements
- R1: An energy passes threshold Tn when the energy, read as unsigned, is greater than or equal to the value held for Tn.
- R2: For each position, the 3-bit code is n for the highest-numbered threshold Tn that the energy passes, or 0 when it passes none. This holds even when the threshold values are not in ascending order.
- R3: The code for position p sits at `out_code[3p+2:3p]`.
- R4: For k = 0 to 5, `out_count[2k+1:2k]` holds the number of positions that pass threshold T(k+1), saturating at 3. T7 is not counted.
- R5: The mask for position p is `out_mask[8p+7:8p]`. Bit k of that mask is set when T(k+1) is passed, and bit 7 is always 0.
- R6: When `thr_we` is high and `thr_addr` is 0 to 6, the write loads T(thr_addr+1) with `thr_wdata`. Address 7 is ignored. A write applies to inputs accepted on later edges, not to an input accepted on the same edge.
- R7: After reset, all thresholds hold all-ones, `out_valid` is 0 and `in_ready` is 1.
- R8: An input is accepted on an edge where `in_valid` and `in_ready` are both high. Its results appear with `out_valid` high from the next cycle. `out_valid` drops after a transfer (`out_valid` and `out_ready` both high) if no new input is accepted on that edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | 3 | Threshold index (0 means T1) |
| thr_wdata | input | 12 | Threshold value |
| in_valid | input | 1 | Input energies valid |
| in_ready | output | 1 | Block can accept input |
| in_energy | input | 48 | Four 12-bit energies, position 0 in the low bits |
| out_valid | output | 1 | Results valid |
| out_ready | input | 1 | Sink takes the results |
| out_code | output | 12 | Four 3-bit highest-threshold codes |
| out_count | output | 12 | Six 2-bit saturating counts |
| out_mask | output | 32 | Four 8-bit pass masks |

## Verification
All three results are due in the cycle after their input is accepted, and they stay there for as long as the sink stalls. `in_ready` is combinational and is due in the same cycle as `out_ready`. The bench drives inputs at the falling edge. It checks `in_ready` a moment later, in that same half cycle, and it checks the registered results at the next falling edge against a model that steps once per rising edge. The model applies a threshold write only after it has evaluated the input accepted on the same edge, so the ordering in R6 is tested directly.

// File: rtl/thr_enc_pkg.sv
package thr_enc_pkg;
  localparam int MASK_W = 8;
  localparam int CNT_W  = 2;
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  function automatic logic [CNT_W-1:0] sat_count(input int unsigned n);
    if (n > int'(CNT_SAT)) return CNT_SAT;
    return n[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/thr_bank.sv
module thr_bank #(
  parameter int EW   = 12,
  parameter int NTHR = 7,
  parameter int AW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [EW-1:0]      wdata,
  output logic [NTHR*EW-1:0] thr_flat
);
  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    logic [EW-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n)                             val <= '1;
      else if (we && addr == AW'(k))          val <= wdata;
    end
    assign thr_flat[k*EW +: EW] = val;
  end

  AST_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(addr) >= NTHR) |=> $stable(thr_flat)); // R6
endmodule

// File: rtl/thr_compare.sv
module thr_compare #(
  parameter int EW     = 12,
  parameter int NTHR   = 7,
  parameter int CODE_W = 3
) (
  input  logic [EW-1:0]      energy,
  input  logic [NTHR*EW-1:0] thr_flat,
  output logic [NTHR-1:0]    pass,
  output logic [CODE_W-1:0]  code
);
  for (genvar k = 0; k < NTHR; k++) begin : g_cmp
    assign pass[k] = (energy >= thr_flat[k*EW +: EW]);
  end

  always_comb begin
    code = '0;
    for (int k = 0; k < NTHR; k++)
      if (pass[k]) code = CODE_W'(k + 1);
  end
endmodule

// File: rtl/thr_count.sv
module thr_count
  import thr_enc_pkg::*;
#(
  parameter int NPOS = 4,
  parameter int NTHR = 7,
  parameter int NCNT = 6
) (
  input  logic [NPOS*NTHR-1:0]  pass_all,
  output logic [NCNT*CNT_W-1:0] cnt_flat
);
  for (genvar k = 0; k < NCNT; k++) begin : g_col
    logic [NPOS-1:0] col;
    for (genvar p = 0; p < NPOS; p++) begin : g_pos
      assign col[p] = pass_all[p*NTHR + k];
    end
    assign cnt_flat[k*CNT_W +: CNT_W] = sat_count($countones(col));
  end
endmodule

// File: rtl/thr_result_encoder.sv
module thr_result_encoder
  import thr_enc_pkg::*;
#(
  parameter int EW   = 12,
  parameter int NPOS = 4,
  parameter int NTHR = 7,
  parameter int NCNT = 6,
  localparam int AW     = $clog2(NTHR + 1),
  localparam int CODE_W = $clog2(NTHR + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     thr_we,
  input  logic [AW-1:0]            thr_addr,
  input  logic [EW-1:0]            thr_wdata,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NPOS*EW-1:0]       in_energy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NPOS*CODE_W-1:0]   out_code,
  output logic [NCNT*CNT_W-1:0]    out_count,
  output logic [NPOS*MASK_W-1:0]   out_mask
);
  logic [NTHR*EW-1:0]      thr_flat;
  logic [NPOS*NTHR-1:0]    pass_all;
  logic [NPOS*CODE_W-1:0]  nxt_code;
  logic [NPOS*MASK_W-1:0]  nxt_mask;
  logic [NCNT*CNT_W-1:0]   nxt_count;
  logic                    accept;

  thr_bank #(.EW(EW), .NTHR(NTHR), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(thr_we), .addr(thr_addr),
    .wdata(thr_wdata), .thr_flat(thr_flat)
  );

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    logic [NTHR-1:0] pass_p;
    thr_compare #(.EW(EW), .NTHR(NTHR), .CODE_W(CODE_W)) u_cmp (
      .energy(in_energy[p*EW +: EW]), .thr_flat(thr_flat),
      .pass(pass_p), .code(nxt_code[p*CODE_W +: CODE_W])
    );
    assign pass_all[p*NTHR +: NTHR]     = pass_p;
    assign nxt_mask[p*MASK_W +: MASK_W] = {{(MASK_W-NTHR){1'b0}}, pass_p};
  end

  thr_count #(.NPOS(NPOS), .NTHR(NTHR), .NCNT(NCNT)) u_cnt (
    .pass_all(pass_all), .cnt_flat(nxt_count)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
      out_count <= '0;
      out_mask  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_code  <= nxt_code;
      out_count <= nxt_count;
      out_mask  <= nxt_mask;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
  AST_IDLE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)
      && $stable(out_count) && $stable(out_mask))); // R9

  for (genvar p = 0; p < NPOS; p++) begin : g_chk_pos
    AST_CODE_MASK_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_code[p*CODE_W +: CODE_W] == '0)
                     == (out_mask[p*MASK_W +: NTHR] == '0))); // R2
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_chk_cnt
    logic [NPOS-1:0] col_q;
    for (genvar p = 0; p < NPOS; p++) begin : g_b
      assign col_q[p] = out_mask[p*MASK_W + k];
    end
    AST_COUNT_FROM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count[k*CNT_W +: CNT_W] == sat_count($countones(col_q)))); // R4
  end
endmodule

// File: tb/sim_thr_result_encoder.sv
module sim_thr_result_encoder;
  localparam int CLK_P = 10;
  localparam int EW = 12, NPOS = 4, NTHR = 7, NCNT = 6;

  logic clk = 0, rst_n = 0;
  logic thr_we = 0; logic [2:0] thr_addr = 0; logic [EW-1:0] thr_wdata = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [NPOS*EW-1:0] in_energy = 0;
  logic [11:0] out_code, out_count;
  logic [31:0] out_mask;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit m_valid, n_valid;
  logic [11:0] m_code, m_cnt, n_code, n_cnt;
  logic [31:0] m_mask, n_mask;
  int thr_m[NTHR];

  always #(CLK_P/2) clk = ~clk;

  thr_result_encoder u0 (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_addr(thr_addr),
    .thr_wdata(thr_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_energy(in_energy), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_count(out_count), .out_mask(out_mask)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NPOS*EW-1:0] pk(int a, int b, int c, int d);
    return {d[EW-1:0], c[EW-1:0], b[EW-1:0], a[EW-1:0]};
  endfunction

  // behavioural reference: R1 compare, R2/R3 code, R4 counts, R5 masks
  task automatic ref_eval(input logic [NPOS*EW-1:0] e,
                          output logic [11:0] code, output logic [11:0] cnt,
                          output logic [31:0] mask);
    int n;
    code = 0; cnt = 0; mask = 0;
    for (int p = 0; p < NPOS; p++) begin
      int ev = int'(e[p*EW +: EW]);
      int c = 0;
      for (int k = 0; k < NTHR; k++)
        if (ev >= thr_m[k]) begin c = k + 1; mask[p*8 + k] = 1'b1; end
      code[p*3 +: 3] = c[2:0];
    end
    for (int k = 0; k < NCNT; k++) begin
      n = 0;
      for (int p = 0; p < NPOS; p++) n += int'(mask[p*8 + k]);
      if (n > 3) n = 3;
      cnt[k*2 +: 2] = n[1:0];
    end
  endtask

  task automatic cyc(bit we, int addr, int wd, bit iv, logic [NPOS*EW-1:0] e, bit ordy);
    bit er;
    @(negedge clk);
    chk("R8 out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    if (m_valid) begin
      chk("R2/R3 code", {20'b0, out_code}, {20'b0, m_code});
      chk("R4 count",   {20'b0, out_count}, {20'b0, m_cnt});
      chk("R5 mask",    out_mask, m_mask);
    end
    thr_we = we; thr_addr = addr[2:0]; thr_wdata = wd[EW-1:0];
    in_valid = iv; in_energy = e; out_ready = ordy;
    #1;
    er = !m_valid || ordy;
    chk("R9 in_ready", {31'b0, in_ready}, {31'b0, er});
    n_valid = m_valid; n_code = m_code; n_cnt = m_cnt; n_mask = m_mask;
    if (iv && er) begin
      ref_eval(e, n_code, n_cnt, n_mask);
      n_valid = 1;
    end else if (ordy) n_valid = 0;
    if (we && addr < NTHR) thr_m[addr] = wd;   // R6: after same-edge evaluation
    @(posedge clk);
    m_valid = n_valid; m_code = n_code; m_cnt = n_cnt; m_mask = n_mask;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_valid = 0; m_code = 0; m_cnt = 0; m_mask = 0;
    for (int k = 0; k < NTHR; k++) thr_m[k] = (1 << EW) - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R7 reset in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1;
    // R7: reset thresholds are all-ones, so only full-scale passes
    cyc(0, 0, 0, 1, pk(4095, 4094, 4095, 0), 1);
    cyc(0, 0, 0, 1, pk(4095, 4095, 4095, 4095), 1);   // R4 saturation at 3
    // R6: load ascending thresholds 100..700
    for (int k = 0; k < NTHR; k++) cyc(1, k, 100 * (k + 1), 0, 0, 1);
    // R1 boundary: equal passes, one below fails
    cyc(0, 0, 0, 1, pk(99, 100, 650, 700), 1);
    cyc(0, 0, 0, 1, pk(199, 200, 699, 4095), 1);
    // R6: address 7 ignored
    cyc(1, 7, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, pk(50, 150, 250, 350), 1);
    // R6: write on the same edge as an accepted input affects only later inputs
    cyc(1, 3, 50, 1, pk(60, 60, 60, 60), 1);
    cyc(0, 0, 0, 1, pk(60, 60, 60, 60), 1);
    // R2: non-monotonic, T7 lowest
    cyc(1, 6, 10, 0, 0, 1);
    cyc(0, 0, 0, 1, pk(20, 5, 120, 800), 1);
    // R9: back-pressure with input pending
    cyc(0, 0, 0, 1, pk(300, 400, 500, 600), 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, pk(1, 2, 3, 4), 0);
    cyc(0, 0, 0, 1, pk(1, 2, 3, 4), 1);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);   // R8 drain
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 4) == 0);
      cyc(we, $urandom_range(0, 7), $urandom_range(0, 1023),
          $urandom_range(0, 3) != 0,
          pk($urandom_range(0, 1100), $urandom_range(0, 1100),
             $urandom_range(0, 1100), $urandom_range(0, 1100)),
          $urandom_range(0, 3) != 0);
    end
    cyc(0, 0, 0, 0, 0, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule